// File: doc/BRIEF.md
# Bus-Cycle Trace Ring Buffer

This block records one 32-bit record for every bus cycle of an emulated 8-bit processor. It keeps the most recent cycles in a circular store of 252 entries. Each record holds the cycle's address, data, read and write strobes, three cycle-type flags and two breakpoint-hit flags. Capture follows the bus-cycle strobe directly, whether the processor runs freely or is single-stepped, so the history stays in order. An external hold input suppresses capture.

While the processor is paused, an operator moves a display index through the stored history. The index is measured as an age: 0 is the newest record and `fill_count-1` is the oldest still held. A stop event sets the index to a starting record. After a breakpoint stop this is the record that raised the breakpoint. After a manual stop it is the latest opcode fetch. With fetch-only review asserted, each step moves to the nearest opcode-fetch record in the chosen direction. The block finds that record with a scan that examines one record per clock.

Top module: `trc_ring`

## Requirements
- R1: A captured record is presented on `view_rec` with this layout: address in bits 15:0, data in bits 23:16, read strobe in bit 24, write strobe in bit 25, opcode fetch in bit 26, I/O in bit 27, interrupt acknowledge in bit 28, comparator breakpoint in bit 29, external breakpoint in bit 30, and bit 31 zero.
- R2: A record is stored on a clock edge where `bus_cycle` is 1 and `trace_hold` is 0. While `trace_hold` is 1, bus cycles change neither `fill_count` nor the view.
- R3: `fill_count` rises by one for each stored record and saturates at 252.
- R4: After more than 252 records, each new record overwrites the oldest one. The record at age 251 is the 252nd most recent, and the records keep their chronological order.
- R5: After reset, `fill_count`, `view_age` and `view_rec` are zero and `nav_busy` is low.
- R6: Step commands take effect only while `run` is 0 and `nav_busy` is 0, with exactly one of `step_older` and `step_newer` asserted. Otherwise the view is unchanged.
- R7: A plain older step increases `view_age` by one but never past `fill_count-1`. A plain newer step decreases it by one but never below 0. The new view is visible after the next clock edge.
- R8: A fetch-only step scans one record per clock, with `nav_busy` high, toward the nearest record in the chosen direction that has bit 26 set, and places the view there. If no such record exists before the oldest or newest boundary, the view is left unchanged.
- R9: On `stop_evt`, the view is placed on a starting record. If `stop_bkpt` is 1, this is the most recent stored record with bit 29 or bit 30 set. If `stop_bkpt` is 0, it is the most recent stored record with bit 26 set. If no stored record matches, the view is placed at age 0.
- R10: Storing a record moves the view to age 0 and ends any scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cycle | input | 1 | One bus cycle completes on this edge |
| bus_addr | input | 16 | Cycle address |
| bus_data | input | 8 | Cycle data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_fetch | input | 1 | Cycle is an opcode fetch |
| bus_io | input | 1 | Cycle is an I/O transfer |
| bus_iack | input | 1 | Cycle is an interrupt acknowledge |
| bkpt_cmp | input | 1 | Comparator breakpoint hit in this cycle |
| bkpt_ext | input | 1 | External breakpoint hit in this cycle |
| trace_hold | input | 1 | Suppresses capture while 1 |
| run | input | 1 | 1 while the processor runs; review needs 0 |
| stop_evt | input | 1 | One-cycle pulse when the processor stops |
| stop_bkpt | input | 1 | Cause of the stop: 1 breakpoint, 0 manual |
| step_newer | input | 1 | Step toward newer records |
| step_older | input | 1 | Step toward older records |
| fetch_only | input | 1 | Steps skip records that are not opcode fetches |
| view_rec | output | 32 | Record at the current view (zero when empty) |
| view_age | output | 8 | Age of the viewed record, 0 = newest |
| fill_count | output | 8 | Number of valid stored records |
| nav_busy | output | 1 | Fetch-only scan in progress |

## Verification
The hardest condition to reach is the oldest slot once the write pointer has wrapped. There the age-to-slot mapping crosses the modulo-252 seam, so a reviewed record is valid only if the pointer arithmetic is correct. To get there, the stimulus stores 300 records with varied fields, then steps back past the oldest entry and compares the record shown with the 252nd most recent one pushed. A second hard case is a capture that arrives while a fetch-only scan is still busy. The bench starts a scan and presents a bus cycle on the very next clock.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;

    localparam int REC_W = 32;

    // One captured bus cycle; field order fixes the bit layout of a record.
    typedef struct packed {
        logic        spare;
        logic        bk_ext;
        logic        bk_cmp;
        logic        iack;
        logic        io;
        logic        fetch;
        logic        wr;
        logic        rd;
        logic [7:0]  data;
        logic [15:0] addr;
    } trc_rec_t;

    typedef enum logic [1:0] {
        NAV_IDLE,
        NAV_SCAN_OLD,
        NAV_SCAN_NEW
    } nav_state_e;

    // Slot holding the record 'age' cycles older than slot 'head' (age < depth).
    function automatic int ring_back(input int head, input int age, input int depth);
        int t;
        t = head - age;
        if (t < 0) t = t + depth;
        return t;
    endfunction

endpackage

// File: rtl/trc_store.sv
`timescale 1ns/1ps
module trc_store
    import trc_pkg::*;
#(
    parameter int DEPTH = 252,
    parameter int PW    = 8,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  trc_rec_t      wr_rec,
    input  logic [PW-1:0] rd_a_ptr,
    input  logic [PW-1:0] rd_b_ptr,
    output trc_rec_t      rd_a_rec,
    output trc_rec_t      rd_b_rec,
    output logic [PW-1:0] head_ptr,
    output logic [CW-1:0] fill
);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    trc_rec_t      mem [DEPTH];
    logic [PW-1:0] wr_ptr_q;
    logic [CW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            fill_q   <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
            if (fill_q != FULL_CNT) fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr_q] <= wr_rec;
    end

    assign head_ptr = (wr_ptr_q == '0) ? LAST_SLOT : wr_ptr_q - 1'b1;
    assign fill     = fill_q;
    assign rd_a_rec = (fill_q == '0) ? '0 : mem[rd_a_ptr];
    assign rd_b_rec = (fill_q == '0) ? '0 : mem[rd_b_ptr];

endmodule

// File: rtl/trc_marks.sv
`timescale 1ns/1ps
module trc_marks
    import trc_pkg::*;
#(
    parameter int DEPTH = 252,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  trc_rec_t      wr_rec,
    input  logic [CW-1:0] fill,
    output logic [CW-1:0] fetch_age,
    output logic          fetch_ok,
    output logic [CW-1:0] bkpt_age,
    output logic          bkpt_ok
);
    localparam int            NMARK   = 2;
    localparam logic [CW-1:0] AGE_SAT = CW'(DEPTH);

    logic [NMARK-1:0]         hit;
    logic [NMARK-1:0]         mark_ok;
    logic [NMARK-1:0][CW-1:0] mark_age;

    assign hit[0] = wr_rec.fetch;
    assign hit[1] = wr_rec.bk_cmp | wr_rec.bk_ext;

    for (genvar g = 0; g < NMARK; g++) begin : g_mark
        logic          seen_q;
        logic [CW-1:0] age_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_q <= 1'b0;
                age_q  <= '0;
            end else if (wr_en) begin
                if (hit[g]) begin
                    seen_q <= 1'b1;
                    age_q  <= '0;
                end else if (age_q != AGE_SAT) begin
                    age_q <= age_q + 1'b1;
                end
            end
        end

        assign mark_ok[g]  = seen_q && (age_q < fill);
        assign mark_age[g] = age_q;
    end

    assign fetch_age = mark_age[0];
    assign fetch_ok  = mark_ok[0];
    assign bkpt_age  = mark_age[1];
    assign bkpt_ok   = mark_ok[1];

endmodule

// File: rtl/trc_nav.sv
`timescale 1ns/1ps
module trc_nav
    import trc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cap_en,
    input  logic          stop_evt,
    input  logic          stop_bkpt,
    input  logic          step_newer,
    input  logic          step_older,
    input  logic          fetch_only,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] fetch_age,
    input  logic          fetch_ok,
    input  logic [CW-1:0] bkpt_age,
    input  logic          bkpt_ok,
    input  logic          probe_fetch,
    output logic [CW-1:0] view_age,
    output logic [CW-1:0] probe_age,
    output logic          busy
);
    nav_state_e    st_q;
    logic [CW-1:0] view_q;
    logic [CW-1:0] scan_q;
    logic          cmd_ok;
    logic          at_bound;

    assign cmd_ok = !run && (fill != '0) && (step_newer ^ step_older);

    always_comb begin
        probe_age = scan_q;
        at_bound  = 1'b1;
        if (st_q == NAV_SCAN_OLD) begin
            probe_age = scan_q + 1'b1;
            at_bound  = (scan_q + 1'b1) == fill;
        end else if (st_q == NAV_SCAN_NEW) begin
            probe_age = scan_q - 1'b1;
            at_bound  = (scan_q == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= NAV_IDLE;
            view_q <= '0;
            scan_q <= '0;
        end else if (cap_en) begin
            st_q   <= NAV_IDLE;
            view_q <= '0;
        end else if (stop_evt) begin
            st_q <= NAV_IDLE;
            if (stop_bkpt) view_q <= bkpt_ok ? bkpt_age : '0;
            else           view_q <= fetch_ok ? fetch_age : '0;
        end else begin
            case (st_q)
                NAV_IDLE: begin
                    if (cmd_ok) begin
                        if (fetch_only) begin
                            scan_q <= view_q;
                            st_q   <= step_older ? NAV_SCAN_OLD : NAV_SCAN_NEW;
                        end else if (step_older) begin
                            if ((view_q + 1'b1) < fill) view_q <= view_q + 1'b1;
                        end else if (view_q != '0) begin
                            view_q <= view_q - 1'b1;
                        end
                    end
                end
                NAV_SCAN_OLD, NAV_SCAN_NEW: begin
                    if (at_bound) begin
                        st_q <= NAV_IDLE;
                    end else if (probe_fetch) begin
                        view_q <= probe_age;
                        st_q   <= NAV_IDLE;
                    end else begin
                        scan_q <= probe_age;
                    end
                end
                default: st_q <= NAV_IDLE;
            endcase
        end
    end

    assign view_age = view_q;
    assign busy     = (st_q != NAV_IDLE);

endmodule

// File: rtl/trc_ring.sv
`timescale 1ns/1ps
module trc_ring
    import trc_pkg::*;
#(
    parameter int DEPTH = 252
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_cycle,
    input  logic [15:0]                  bus_addr,
    input  logic [7:0]                   bus_data,
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    input  logic                         bus_fetch,
    input  logic                         bus_io,
    input  logic                         bus_iack,
    input  logic                         bkpt_cmp,
    input  logic                         bkpt_ext,
    input  logic                         trace_hold,
    input  logic                         run,
    input  logic                         stop_evt,
    input  logic                         stop_bkpt,
    input  logic                         step_newer,
    input  logic                         step_older,
    input  logic                         fetch_only,
    output logic [REC_W-1:0]             view_rec,
    output logic [$clog2(DEPTH+1)-1:0]   view_age,
    output logic [$clog2(DEPTH+1)-1:0]   fill_count,
    output logic                         nav_busy
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          cap_en;
    trc_rec_t      cap_rec;
    trc_rec_t      view_r;
    trc_rec_t      probe_r;
    logic [PW-1:0] head_ptr;
    logic [PW-1:0] view_ptr;
    logic [PW-1:0] probe_ptr;
    logic [CW-1:0] fill;
    logic [CW-1:0] age_q;
    logic [CW-1:0] probe_age;
    logic [CW-1:0] fetch_age;
    logic [CW-1:0] bkpt_age;
    logic          fetch_ok;
    logic          bkpt_ok;
    logic          busy;

    assign cap_en = bus_cycle & ~trace_hold;

    always_comb begin
        cap_rec        = '0;
        cap_rec.addr   = bus_addr;
        cap_rec.data   = bus_data;
        cap_rec.rd     = bus_rd;
        cap_rec.wr     = bus_wr;
        cap_rec.fetch  = bus_fetch;
        cap_rec.io     = bus_io;
        cap_rec.iack   = bus_iack;
        cap_rec.bk_cmp = bkpt_cmp;
        cap_rec.bk_ext = bkpt_ext;
    end

    assign view_ptr  = PW'(ring_back(int'(head_ptr), int'(age_q), DEPTH));
    assign probe_ptr = PW'(ring_back(int'(head_ptr), int'(probe_age), DEPTH));

    trc_store #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cap_en),
        .wr_rec   (cap_rec),
        .rd_a_ptr (view_ptr),
        .rd_b_ptr (probe_ptr),
        .rd_a_rec (view_r),
        .rd_b_rec (probe_r),
        .head_ptr (head_ptr),
        .fill     (fill)
    );

    trc_marks #(.DEPTH(DEPTH), .CW(CW)) u_marks (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cap_en),
        .wr_rec    (cap_rec),
        .fill      (fill),
        .fetch_age (fetch_age),
        .fetch_ok  (fetch_ok),
        .bkpt_age  (bkpt_age),
        .bkpt_ok   (bkpt_ok)
    );

    trc_nav #(.CW(CW)) u_nav (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cap_en      (cap_en),
        .stop_evt    (stop_evt),
        .stop_bkpt   (stop_bkpt),
        .step_newer  (step_newer),
        .step_older  (step_older),
        .fetch_only  (fetch_only),
        .fill        (fill),
        .fetch_age   (fetch_age),
        .fetch_ok    (fetch_ok),
        .bkpt_age    (bkpt_age),
        .bkpt_ok     (bkpt_ok),
        .probe_fetch (probe_r.fetch),
        .view_age    (age_q),
        .probe_age   (probe_age),
        .busy        (busy)
    );

    assign view_rec   = view_r;
    assign view_age   = age_q;
    assign fill_count = fill;
    assign nav_busy   = busy;

endmodule

// File: rtl/trc_ring_chk.sv
`timescale 1ns/1ps
module trc_ring_chk #(
    parameter int DEPTH = 252,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_cycle,
    input logic          trace_hold,
    input logic          run,
    input logic          stop_evt,
    input logic          step_newer,
    input logic          step_older,
    input logic          fetch_only,
    input logic [31:0]   view_rec,
    input logic [CW-1:0] view_age,
    input logic [CW-1:0] fill_count,
    input logic          nav_busy
);
    logic cap;
    assign cap = bus_cycle & ~trace_hold;

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CW'(DEPTH)); // R3
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
        (cap && fill_count != CW'(DEPTH)) |=> fill_count == CW'($past(fill_count) + 1'b1)); // R3
    AST_HOLD_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(fill_count)); // R2
    AST_EMPTY_VIEW: assert property (@(posedge clk) disable iff (rst)
        fill_count == '0 |-> (view_rec == '0 && view_age == '0)); // R5
    AST_AGE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        fill_count != '0 |-> view_age < fill_count); // R7
    AST_CAPTURE_NEWEST: assert property (@(posedge clk) disable iff (rst)
        cap |=> (view_age == '0 && !nav_busy)); // R10
    AST_RUN_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (run && !nav_busy && !cap && !stop_evt) |=> $stable(view_age)); // R6
    AST_PLAIN_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!run && !nav_busy && !cap && !stop_evt && !fetch_only && (step_older ^ step_newer))
        |=> (view_age == $past(view_age) || view_age == CW'($past(view_age) + 1'b1)
             || CW'(view_age + 1'b1) == $past(view_age))); // R7
    AST_SCAN_LANDS_FETCH: assert property (@(posedge clk) disable iff (rst)
        (nav_busy && !cap && !stop_evt) |=> (nav_busy || $stable(view_age) || view_rec[26])); // R8

endmodule

bind trc_ring trc_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_cycle  (bus_cycle),
    .trace_hold (trace_hold),
    .run        (run),
    .stop_evt   (stop_evt),
    .step_newer (step_newer),
    .step_older (step_older),
    .fetch_only (fetch_only),
    .view_rec   (view_rec),
    .view_age   (view_age),
    .fill_count (fill_count),
    .nav_busy   (nav_busy)
);

// File: tb/sim_trc_ring.sv
`timescale 1ns/1ps
module sim_trc_ring;

    localparam int DEPTH = 252;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cycle = 0, bus_rd = 0, bus_wr = 0, bus_fetch = 0, bus_io = 0, bus_iack = 0;
    logic        bkpt_cmp = 0, bkpt_ext = 0, trace_hold = 0, run = 1;
    logic        stop_evt = 0, stop_bkpt = 0, step_newer = 0, step_older = 0, fetch_only = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [31:0] view_rec;
    logic [7:0]  view_age;
    logic [7:0]  fill_count;
    logic        nav_busy;

    always #2 clk = ~clk;

    trc_ring #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .bus_cycle(bus_cycle), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_fetch(bus_fetch), .bus_io(bus_io),
        .bus_iack(bus_iack), .bkpt_cmp(bkpt_cmp), .bkpt_ext(bkpt_ext), .trace_hold(trace_hold),
        .run(run), .stop_evt(stop_evt), .stop_bkpt(stop_bkpt), .step_newer(step_newer),
        .step_older(step_older), .fetch_only(fetch_only), .view_rec(view_rec),
        .view_age(view_age), .fill_count(fill_count), .nav_busy(nav_busy)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] hist[$];
    int mage = 0;

    typedef struct {
        string       req;
        int          age;
        logic [31:0] rec;
        int          fill;
    } exp_t;
    exp_t exp_q[$];
    event item_ev;

    function automatic logic [31:0] mk(input int i);
        logic [31:0] r;
        r        = '0;
        r[15:0]  = 16'(32'h1000 + i * 7);
        r[23:16] = 8'(i) ^ 8'h5A;
        r[24]    = (i % 2 == 1);
        r[25]    = (i % 2 == 0);
        r[26]    = (i % 5 == 0);
        r[27]    = (i % 7 == 3);
        r[28]    = (i % 11 == 4);
        r[29]    = (i % 13 == 6);
        r[30]    = (i % 17 == 9);
        return r;
    endfunction

    function automatic int mfill();
        return (hist.size() > DEPTH) ? DEPTH : hist.size();
    endfunction

    function automatic logic [31:0] mrec(input int a);
        if (hist.size() == 0) return '0;
        return hist[hist.size() - 1 - a];
    endfunction

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(item_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (view_age !== 8'(e.age) || view_rec !== e.rec ||
                    fill_count !== 8'(e.fill) || nav_busy !== 1'b0) begin
                    fails++;
                    $display("FAIL %s: age=%0d rec=%h fill=%0d busy=%b expected age=%0d rec=%h fill=%0d busy=0",
                             e.req, view_age, view_rec, fill_count, nav_busy, e.age, e.rec, e.fill);
                end
            end
        end
    end

    task automatic expect_view(input string req);
        exp_t e;
        e.req  = req;
        e.age  = mage;
        e.rec  = mrec(mage);
        e.fill = mfill();
        exp_q.push_back(e);
        -> item_ev;
        #1;
    endtask

    task automatic drive_bus(input logic [31:0] r);
        bus_addr  = r[15:0];
        bus_data  = r[23:16];
        bus_rd    = r[24];
        bus_wr    = r[25];
        bus_fetch = r[26];
        bus_io    = r[27];
        bus_iack  = r[28];
        bkpt_cmp  = r[29];
        bkpt_ext  = r[30];
    endtask

    task automatic cap(input int i, input bit hold);
        @(negedge clk);
        drive_bus(mk(i));
        bus_cycle  = 1'b1;
        trace_hold = hold;
        @(negedge clk);
        bus_cycle  = 1'b0;
        trace_hold = 1'b0;
        if (!hold) begin
            hist.push_back(mk(i));
            mage = 0;
        end
    endtask

    task automatic cmd(input bit older, input bit newer, input bit fo);
        int f;
        @(negedge clk);
        step_older = older;
        step_newer = newer;
        fetch_only = fo;
        @(negedge clk);
        step_older = 1'b0;
        step_newer = 1'b0;
        fetch_only = 1'b0;
        while (nav_busy) @(negedge clk);
        f = mfill();
        if (!run && (older ^ newer) && f > 0) begin
            if (!fo) begin
                if (older && mage < f - 1) mage++;
                if (newer && mage > 0) mage--;
            end else if (older) begin
                for (int a = mage + 1; a < f; a++)
                    if (mrec(a)[26]) begin mage = a; break; end
            end else begin
                for (int a = mage - 1; a >= 0; a--)
                    if (mrec(a)[26]) begin mage = a; break; end
            end
        end
    endtask

    task automatic stop(input bit bk);
        int f;
        @(negedge clk);
        stop_evt  = 1'b1;
        stop_bkpt = bk;
        @(negedge clk);
        stop_evt  = 1'b0;
        stop_bkpt = 1'b0;
        f    = mfill();
        mage = 0;
        for (int a = 0; a < f; a++) begin
            logic [31:0] r;
            r = mrec(a);
            if (bk ? (r[29] | r[30]) : r[26]) begin mage = a; break; end
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_view("R5 reset state");

        for (int i = 1; i <= 4; i++) cap(i, 0);
        run = 1'b0;
        cmd(1, 0, 0);
        cmd(1, 0, 0);
        expect_view("R7 two older steps");
        stop(0);
        expect_view("R9 manual stop with no fetch stored");

        run = 1'b1;
        cap(5, 0);
        cap(6, 0);
        expect_view("R1 R3 R10 newest record layout");

        for (int i = 7; i <= 9; i++) cap(i, 1);
        expect_view("R2 hold blocks capture");

        cmd(1, 0, 0);
        expect_view("R6 step ignored while running");

        run = 1'b0;
        stop(0);
        expect_view("R9 manual stop on latest fetch");
        for (int k = 0; k < 10; k++) cmd(1, 0, 0);
        expect_view("R7 older saturates at oldest");
        for (int k = 0; k < 8; k++) cmd(0, 1, 0);
        expect_view("R7 newer saturates at newest");
        cmd(1, 1, 0);
        expect_view("R6 both steps ignored");

        cmd(1, 0, 1);
        expect_view("R8 fetch-only older");
        cmd(1, 0, 1);
        expect_view("R8 no older fetch leaves view");
        cmd(0, 1, 1);
        expect_view("R8 no newer fetch leaves view");
        stop(1);
        expect_view("R9 breakpoint stop");

        run = 1'b1;
        for (int i = 10; i < 310; i++) cap(i, 0);
        run = 1'b0;
        expect_view("R3 R4 fill saturates after wrap");
        stop(1);
        expect_view("R9 breakpoint stop after wrap");
        for (int k = 0; k < 260; k++) cmd(1, 0, 0);
        expect_view("R4 oldest record after wrap");
        for (int k = 0; k < 4; k++) begin
            cmd(0, 1, 1);
            expect_view("R8 fetch-only newer after wrap");
        end
        cmd(1, 0, 1);
        expect_view("R8 fetch-only older after wrap");

        // Start a scan from the newest record, then store a record mid-scan.
        for (int k = 0; k < 300; k++) cmd(0, 1, 0);
        @(negedge clk);
        step_older = 1'b1;
        fetch_only = 1'b1;
        @(negedge clk);
        step_older = 1'b0;
        fetch_only = 1'b0;
        checks++;
        if (nav_busy !== 1'b1) begin
            fails++;
            $display("FAIL R8 scan busy: busy=%b expected 1", nav_busy);
        end
        drive_bus(mk(311));
        bus_cycle = 1'b1;
        @(negedge clk);
        bus_cycle = 1'b0;
        hist.push_back(mk(311));
        mage = 0;
        expect_view("R10 capture ends scan");

        finish_run();
    end

endmodule